// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed binary-coded decimal bytes. A free-running enable at 32.768 kHz feeds a prescaler. The prescaler raises a one-second strobe after every `PRESCALE_DIV` enable pulses. On that strobe the block advances seconds, minutes, hours, day of week, date, month and a two-digit year. Carries ripple through the fields in the same clock edge. Month lengths and leap Februaries are handled. The hours byte carries its own format bit, so 12-hour and 24-hour time can both be used.

Software reaches the block through a register port. A single-cycle write strobe loads one field. The read side works in bursts. Pulsing `rd_begin` freezes a copy of all seven time fields, and `rd_data` then returns bytes from that copy for any `rd_addr` while the live counters keep running. A halt bit in the control byte stops the prescaler and so stops all counting. Loading seconds restarts the sub-second phase, so the first advance after a seconds load comes a full second later. Alarm logic can use the `update_tick` output, which pulses once after every advance.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the live fields hold 00 s, 00 min, hour byte 0x00 (24-hour midnight), weekday 0x01, date 0x01, month 0x01, year 0x00. The control byte reads 0x80 (halted), and no advance occurs until the halt bit is cleared.
- R2: While running, the fields advance once for every `PRESCALE_DIV` cycles with `osc_tick` high. `update_tick` is high for exactly the one cycle after each advance edge and low at all other times.
- R3: Seconds at address 0 and minutes at address 1 count in BCD from 0x00 to 0x59. Going from 0x59 to 0x00 carries into the next field.
- R4: If bit 6 of the hours byte (address 2) is 0, bits 5:0 count in BCD from 0x00 to 0x23. Going from 0x23 to 0x00 carries into the day fields.
- R5: If bit 6 of the hours byte is 1, bits 4:0 hold 01..12 in BCD and bit 5 marks PM. 11 rolls to 12 and toggles bit 5. 12 rolls to 01 and keeps bit 5. The day carry happens only on the 11 PM to 12 AM step.
- R6: The weekday byte (address 3) increments on each day carry and wraps from 0x07 to 0x01.
- R7: The date (address 4) wraps to 0x01 after 0x31, 0x30 or 0x28 according to the month (address 5). In February it wraps after 0x29 when the year (address 6) is a multiple of four. The month wraps from 0x12 to 0x01 and increments the year. The year wraps from 0x99 to 0x00.
- R8: A write to address 0 restarts the prescaler. The next advance comes exactly `PRESCALE_DIV` enable pulses after the write edge, and no advance happens on the write edge itself.
- R9: A write to any other field changes only that field and leaves the prescaler phase unchanged.
- R10: A high `rd_begin` at a clock edge copies all seven fields. From then on, `rd_data` for addresses 0..6 returns that copy unchanged until the next `rd_begin`, even while the live fields advance.
- R11: Address 7 is the control byte. Bit 7 is the halt bit, and while it is 1 no field advances and `update_tick` stays low. Address 7 reads back live and is not frozen by the snapshot.
- R12: Unused bits read 0 whatever is written. The kept bits are 0x7F for seconds, minutes and hours, 0x07 for weekday, 0x3F for date, 0x1F for month, 0xFF for year and 0x80 for control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en | input | 1 | Write strobe for one register |
| wr_addr | input | 3 | Register written (0..6 time fields, 7 control) |
| wr_data | input | 8 | Write data, masked per R12 |
| rd_begin | input | 1 | Start of a read burst; captures the snapshot |
| rd_addr | input | 3 | Register read |
| rd_data | output | 8 | Snapshot byte (0..6) or live control byte (7) |
| update_tick | output | 1 | One-cycle pulse after each advance |

## Verification
The range checks on seconds and weekday assume software writes only legal BCD values. The block's behaviour on illegal entries is undefined. The bench writes only encoded legal values, and its masking test uses raw bytes whose kept bits still form legal values. The no-spurious-change property assumes that `wr_en` is a single-cycle strobe. The bench sweeps every hour in both formats and every month end across leap, common and wrapping years, with `PRESCALE_DIV` set to 4. Its expected fields come from a binary time model that is converted to BCD.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;

   localparam int ADDR_W     = 3;
   localparam int NUM_FIELDS = 7;
   localparam int NUM_SLOTS  = 2 ** ADDR_W;

   typedef logic [7:0] tk_byte_t;

   typedef enum logic [ADDR_W-1:0] {
      A_SEC   = 3'd0,
      A_MIN   = 3'd1,
      A_HOUR  = 3'd2,
      A_WDAY  = 3'd3,
      A_DATE  = 3'd4,
      A_MONTH = 3'd5,
      A_YEAR  = 3'd6,
      A_CTRL  = 3'd7
   } tk_addr_e;

   // bits that each register keeps on a write
   function automatic tk_byte_t keep_mask(input logic [ADDR_W-1:0] a);
      case (a)
         A_SEC, A_MIN, A_HOUR: return 8'h7F;
         A_WDAY:               return 8'h07;
         A_DATE:               return 8'h3F;
         A_MONTH:              return 8'h1F;
         A_YEAR:               return 8'hFF;
         default:              return 8'h80;
      endcase
   endfunction

   // two-digit BCD increment, no wrap handling
   function automatic tk_byte_t bcd_inc(input tk_byte_t v);
      if (v[3:0] == 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      else
         return {v[7:4], v[3:0] + 4'd1};
   endfunction

endpackage

// File: rtl/tk_prescaler.sv
`timescale 1ns/1ps
module tk_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick_en,
   input  logic restart,
   output logic strobe
);
   localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam bit            POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt;

   initial begin
      assert (DIV >= 2) else $error("tk_prescaler: DIV must be at least 2");
   end

   assign strobe = run && tick_en && !restart && (cnt == LAST);

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n || restart)    cnt <= '0;
            else if (run && tick_en)  cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || restart)    cnt <= '0;
            else if (run && tick_en)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/tk_calendar.sv
`timescale 1ns/1ps
module tk_calendar
   import tk_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    advance,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  tk_byte_t                wr_data,
   output logic [NUM_FIELDS*8-1:0] fields_o
);
   tk_byte_t sec_q, min_q, hour_q, wday_q, date_q, mon_q, year_q;
   tk_byte_t sec_d, min_d, hour_d, wday_d, date_d, mon_d, year_d;
   tk_byte_t month_end, hr12_inc;
   logic     c_min, c_hour, c_day, c_mon, c_year, leap;

   always_comb begin
      // multiple of four: (2*tens + ones) mod 4 == 0
      leap = (({year_q[4], 1'b0} + year_q[1:0]) == 2'b00);
      case (mon_q)
         8'h02:                      month_end = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
         default:                    month_end = 8'h31;
      endcase
      hr12_inc = bcd_inc({3'b000, hour_q[4:0]});

      sec_d  = sec_q;  min_d  = min_q;  hour_d = hour_q;
      wday_d = wday_q; date_d = date_q; mon_d  = mon_q;  year_d = year_q;
      c_min = 1'b0; c_hour = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_year = 1'b0;

      if (advance) begin
         if (sec_q == 8'h59) begin sec_d = 8'h00; c_min = 1'b1; end
         else                      sec_d = bcd_inc(sec_q);
      end
      if (c_min) begin
         if (min_q == 8'h59) begin min_d = 8'h00; c_hour = 1'b1; end
         else                      min_d = bcd_inc(min_q);
      end
      if (c_hour) begin
         if (hour_q[6]) begin
            if (hour_q[4:0] == 5'h11) begin
               hour_d = {2'b01, ~hour_q[5], 5'h12};
               c_day  = hour_q[5];
            end else if (hour_q[4:0] == 5'h12) begin
               hour_d = {2'b01, hour_q[5], 5'h01};
            end else begin
               hour_d = {2'b01, hour_q[5], hr12_inc[4:0]};
            end
         end else if (hour_q[5:0] == 6'h23) begin
            hour_d = 8'h00;
            c_day  = 1'b1;
         end else begin
            hour_d = bcd_inc(hour_q);
         end
      end
      if (c_day) begin
         wday_d = (wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01;
         if (date_q == month_end) begin date_d = 8'h01; c_mon = 1'b1; end
         else                           date_d = bcd_inc(date_q);
      end
      if (c_mon) begin
         if (mon_q == 8'h12) begin mon_d = 8'h01; c_year = 1'b1; end
         else                      mon_d = bcd_inc(mon_q);
      end
      if (c_year)
         year_d = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);

      if (wr_en) begin
         case (wr_addr)
            A_SEC:   sec_d  = wr_data;
            A_MIN:   min_d  = wr_data;
            A_HOUR:  hour_d = wr_data;
            A_WDAY:  wday_d = wr_data;
            A_DATE:  date_d = wr_data;
            A_MONTH: mon_d  = wr_data;
            A_YEAR:  year_d = wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= 8'h00; min_q  <= 8'h00; hour_q <= 8'h00;
         wday_q <= 8'h01; date_q <= 8'h01; mon_q  <= 8'h01; year_q <= 8'h00;
      end else begin
         sec_q  <= sec_d;  min_q  <= min_d;  hour_q <= hour_d;
         wday_q <= wday_d; date_q <= date_d; mon_q  <= mon_d;  year_q <= year_d;
      end
   end

   assign fields_o = {year_q, mon_q, date_q, wday_q, hour_q, min_q, sec_q};

endmodule

// File: rtl/tk_snapshot.sv
`timescale 1ns/1ps
module tk_snapshot
   import tk_pkg::*;
#(
   parameter int N = NUM_FIELDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [N*8-1:0]     live,
   input  logic               halt,
   input  logic [ADDR_W-1:0]  rd_addr,
   output tk_byte_t           rd_data,
   output logic [N*8-1:0]     snap_o
);
   logic [NUM_SLOTS*8-1:0] slots;

   initial begin
      assert (N < NUM_SLOTS) else $error("tk_snapshot: no slot left for control");
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_fld
         tk_byte_t q;
         always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (capture) q <= live[i*8 +: 8];
         end
         assign slots[i*8 +: 8]  = q;
         assign snap_o[i*8 +: 8] = q;
      end
      for (genvar j = N; j < NUM_SLOTS; j++) begin : g_pad
         if (j == int'(A_CTRL)) begin : g_ctrl
            assign slots[j*8 +: 8] = {halt, 7'b0};
         end else begin : g_zero
            assign slots[j*8 +: 8] = 8'h00;
         end
      end
   endgenerate

   assign rd_data = slots[rd_addr*8 +: 8];

endmodule

// File: rtl/bcd_timekeeper.sv
`timescale 1ns/1ps
module bcd_timekeeper
   import tk_pkg::*;
#(
   parameter int PRESCALE_DIV = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_begin,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              update_tick
);
   logic                    halt_q;
   logic                    sec_load;
   logic                    strobe;
   tk_byte_t                wr_kept;
   logic [NUM_FIELDS*8-1:0] live_fields;
   logic [NUM_FIELDS*8-1:0] snap_fields;

   assign wr_kept  = wr_data & keep_mask(wr_addr);
   assign sec_load = wr_en && (wr_addr == A_SEC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q      <= 1'b1;
         update_tick <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == A_CTRL)) halt_q <= wr_kept[7];
         update_tick <= strobe;
      end
   end

   tk_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(!halt_q), .tick_en(osc_tick),
      .restart(sec_load), .strobe(strobe)
   );

   tk_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .advance(strobe), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_kept), .fields_o(live_fields)
   );

   tk_snapshot #(.N(NUM_FIELDS)) u_snap (
      .clk(clk), .rst_n(rst_n), .capture(rd_begin), .live(live_fields),
      .halt(halt_q), .rd_addr(rd_addr), .rd_data(rd_data), .snap_o(snap_fields)
   );

endmodule

// File: rtl/tk_timekeeper_chk.sv
`timescale 1ns/1ps
module tk_timekeeper_chk
   import tk_pkg::*;
(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [ADDR_W-1:0]       wr_addr,
   input logic                    rd_begin,
   input logic                    update_tick,
   input logic                    halt,
   input logic [NUM_FIELDS*8-1:0] live,
   input logic [NUM_FIELDS*8-1:0] snap
);
   // R2
   update_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_tick |=> !update_tick);

   // R2
   no_silent_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !update_tick) |-> (live == $past(live)));

   // R11
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && $past(halt)) |-> !update_tick);

   // R8
   sec_load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_SEC) |=> !update_tick);

   // R10
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_begin |=> (snap == $past(live)));

   // R10
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_begin |=> $stable(snap));

   // R3
   sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live[3:0] <= 4'd9) && (live[7:0] <= 8'h59));

   // R6
   wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live[31:24] >= 8'h01) && (live[31:24] <= 8'h07));

endmodule

bind bcd_timekeeper tk_timekeeper_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .rd_begin(rd_begin), .update_tick(update_tick), .halt(halt_q),
   .live(live_fields), .snap(snap_fields)
);

// File: tb/sim_bcd_timekeeper.sv
`timescale 1ns/1ps
module sim_bcd_timekeeper;
   import tk_pkg::*;

   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst_n, osc_tick, wr_en, rd_begin, update_tick;
   logic [2:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   bit   gap = 1'b0;
   bit   done = 1'b0;
   int   checks = 0;
   int   errors = 0;

   int ms, mm, mh, mwd, md, mmo, my;
   bit m12;

   always #5 clk = ~clk;

   bcd_timekeeper #(.PRESCALE_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_begin(rd_begin),
      .rd_addr(rd_addr), .rd_data(rd_data), .update_tick(update_tick)
   );

   initial begin
      osc_tick = 1'b1;
      forever begin
         @(negedge clk);
         osc_tick = gap ? ~osc_tick : 1'b1;
      end
   end

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(input int mo, input int y);
      case (mo)
         2:             return (y % 4 == 0) ? 29 : 28;
         4, 6, 9, 11:   return 30;
         default:       return 31;
      endcase
   endfunction

   function automatic logic [7:0] enc_hour(input int h, input bit twelve);
      int hr;
      if (!twelve) return bcd(h);
      hr = h % 12;
      if (hr == 0) hr = 12;
      return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(hr);
   endfunction

   task automatic adv_model();
      ms++;
      if (ms == 60) begin
         ms = 0; mm++;
         if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
               mh = 0;
               mwd = (mwd == 7) ? 1 : mwd + 1;
               md++;
               if (md > dim(mmo, my)) begin
                  md = 1; mmo++;
                  if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
               end
            end
         end
      end
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic take_snap();
      rd_begin = 1'b1;
      @(negedge clk);
      rd_begin = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic wait_update(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!update_tick && n < 100);
      if (n >= 100) chk("R2", "update_tick never seen", 0, 1);
   endtask

   task automatic compare_all(input string tag);
      logic [7:0] v;
      peek(A_SEC, v);   chk(tag == "" ? "R3" : tag, "seconds", v, bcd(ms));
      peek(A_MIN, v);   chk(tag == "" ? "R3" : tag, "minutes", v, bcd(mm));
      peek(A_HOUR, v);  chk(tag == "" ? (m12 ? "R5" : "R4") : tag, "hours", v, enc_hour(mh, m12));
      peek(A_WDAY, v);  chk(tag == "" ? "R6" : tag, "weekday", v, bcd(mwd));
      peek(A_DATE, v);  chk(tag == "" ? "R7" : tag, "date", v, bcd(md));
      peek(A_MONTH, v); chk(tag == "" ? "R7" : tag, "month", v, bcd(mmo));
      peek(A_YEAR, v);  chk(tag == "" ? "R7" : tag, "year", v, bcd(my));
   endtask

   task automatic set_time(input int s, input int m, input int h, input int wd,
                           input int d, input int mo, input int y, input bit twelve);
      reg_wr(A_CTRL, 8'h80);
      reg_wr(A_SEC, bcd(s));
      reg_wr(A_MIN, bcd(m));
      reg_wr(A_HOUR, enc_hour(h, twelve));
      reg_wr(A_WDAY, bcd(wd));
      reg_wr(A_DATE, bcd(d));
      reg_wr(A_MONTH, bcd(mo));
      reg_wr(A_YEAR, bcd(y));
      ms = s; mm = m; mh = h; mwd = wd; md = d; mmo = mo; my = y; m12 = twelve;
      reg_wr(A_CTRL, 8'h00);
   endtask

   task automatic run_secs(input int n);
      int w;
      for (int i = 0; i < n; i++) begin
         wait_update(w);
         adv_model();
         take_snap();
         compare_all("");
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n, upd;
      logic [7:0] v;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      rd_begin = 1'b0; rd_addr = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, halted
      upd = 0;
      repeat (12) begin @(negedge clk); if (update_tick) upd++; end
      chk("R1", "advances while halted after reset", upd, 0);
      take_snap();
      peek(A_SEC, v);   chk("R1", "reset seconds", v, 8'h00);
      peek(A_MIN, v);   chk("R1", "reset minutes", v, 8'h00);
      peek(A_HOUR, v);  chk("R1", "reset hours", v, 8'h00);
      peek(A_WDAY, v);  chk("R1", "reset weekday", v, 8'h01);
      peek(A_DATE, v);  chk("R1", "reset date", v, 8'h01);
      peek(A_MONTH, v); chk("R1", "reset month", v, 8'h01);
      peek(A_YEAR, v);  chk("R1", "reset year", v, 8'h00);
      peek(A_CTRL, v);  chk("R1", "reset control", v, 8'h80);

      // R12: unused bits read 0 (still halted)
      reg_wr(A_SEC, 8'h92);
      reg_wr(A_MIN, 8'hC5);
      reg_wr(A_HOUR, 8'hA3);
      reg_wr(A_WDAY, 8'hFE);
      reg_wr(A_DATE, 8'hF1);
      reg_wr(A_MONTH, 8'hF2);
      reg_wr(A_YEAR, 8'h47);
      reg_wr(A_CTRL, 8'hFF);
      take_snap();
      peek(A_SEC, v);   chk("R12", "seconds mask", v, 8'h12);
      peek(A_MIN, v);   chk("R12", "minutes mask", v, 8'h45);
      peek(A_HOUR, v);  chk("R12", "hours mask", v, 8'h23);
      peek(A_WDAY, v);  chk("R12", "weekday mask", v, 8'h06);
      peek(A_DATE, v);  chk("R12", "date mask", v, 8'h31);
      peek(A_MONTH, v); chk("R12", "month mask", v, 8'h12);
      peek(A_YEAR, v);  chk("R12", "year mask", v, 8'h47);
      peek(A_CTRL, v);  chk("R12", "control mask", v, 8'h80);

      // R2: advance spacing, enable every cycle then every other cycle
      set_time(0, 0, 0, 1, 1, 1, 0, 1'b0);
      wait_update(n);
      wait_update(n);
      chk("R2", "cycles between advances, enable always", n, DIV);
      gap = 1'b1;
      wait_update(n);
      wait_update(n);
      wait_update(n);
      chk("R2", "cycles between advances, enable half rate", n, 2 * DIV);
      gap = 1'b0;
      wait_update(n);
      wait_update(n);

      // R4 R5 R6: every hour boundary in both formats
      for (int mode = 0; mode < 2; mode++) begin
         for (int h = 0; h < 24; h++) begin
            set_time(59, 59, h, 7, 15, 6, 10, mode[0]);
            run_secs(2);
         end
      end

      // R7: every month end across multiple-of-four, other and wrapping years
      for (int yi = 0; yi < 4; yi++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            int y;
            y = (yi == 0) ? 0 : (yi == 1) ? 23 : (yi == 2) ? 24 : 99;
            set_time(59, 59, 23, 3, dim(mo, y), mo, y, 1'b0);
            run_secs(2);
         end
      end

      // R8: seconds load restarts the prescaler phase
      set_time(5, 10, 8, 2, 10, 3, 30, 1'b0);
      wait_update(n);
      adv_model();
      @(negedge clk);
      reg_wr(A_SEC, 8'h30);
      ms = 30;
      wait_update(n);
      chk("R8", "negedges from seconds load to advance", n, DIV);
      adv_model();
      take_snap();
      compare_all("R8");

      // R9: other field load keeps the phase
      wait_update(n);
      adv_model();
      @(negedge clk);
      reg_wr(A_MIN, 8'h17);
      mm = 17;
      wait_update(n);
      chk("R9", "negedges from minutes load to advance", n, DIV - 2);
      adv_model();
      take_snap();
      compare_all("R9");

      // R10: snapshot stays frozen while counting
      wait_update(n);
      adv_model();
      take_snap();
      wait_update(n);
      wait_update(n);
      compare_all("R10");
      adv_model();
      adv_model();
      take_snap();
      compare_all("R10");

      // R11: halt stops counting, control reads live
      wait_update(n);
      adv_model();
      reg_wr(A_CTRL, 8'h80);
      upd = 0;
      repeat (40) begin @(negedge clk); if (update_tick) upd++; end
      chk("R11", "advances while halted", upd, 0);
      take_snap();
      compare_all("R11");
      reg_wr(A_CTRL, 8'h00);
      peek(A_CTRL, v);
      chk("R11", "control after release", v, 8'h00);
      run_secs(1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule